// File: doc/BRIEF.md
# Sticky Status Flags with Write Lockout

This block holds one byte of sticky event and error flags for a register map that is reached over a serial link. Other logic reports events to it as one-cycle pulses: a supply dropout, a reset, a failed link CRC, a failed map CRC, an internal converter fault, and the end of a serial frame together with its clock count. The block also checks incoming register addresses itself. Software clears most flags by writing ones to the status address. The converter fault is the exception and only a reset removes it.

Three of the flags mean that the link can no longer be trusted: the link CRC flag, the address flag and the frame bit-count flag. While any of them is set, the block withholds its write permit from every address except the status register. Software can still clear the fault, but a corrupted frame cannot change the configuration. A small check-enable register, also held here, switches each of the four checks on or off.

Top module: `stat_guard`

## Requirements
- R1: On a synchronous active-low reset, `status` becomes 8'h60 (supply flag and reset-seen flag set, everything else clear) and `check_en` becomes 0.
- R2: The flag positions in `status` are: bit 6 supply low, bit 5 reset seen, bit 4 link CRC error, bit 3 map CRC error, bit 2 converter fault, bit 1 address error, bit 0 bit-count error. A qualifying event pulse sets its flag on the next clock edge. A pulse on `ev_reset_seen` (for example a software reset) sets bit 5.
- R3: A write to address 02h clears each flag in bits 6, 5, 4, 3, 1 and 0 whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: The converter fault flag (bit 2) ignores writes and stays set until the next reset.
- R5: When an event and a clearing write for the same flag arrive in the same cycle, the flag ends up set.
- R6: `map_wr_go` is high only for a write whose address lies in 00h..50h, is not 02h, and arrives while bits 4, 1 and 0 of `status` are all clear.
- R7: When `check_en[0]` is 1, a read or write to an address above 50h sets bit 1. When `check_en[0]` is 0, or the address is 50h or below, bit 1 does not change.
- R8: When `check_en[1]` is 1, a `frame_end` pulse whose `frame_bits` value is not a multiple of eight sets bit 0. Any other `frame_end` pulse leaves bit 0 unchanged.
- R9: `ev_link_crc` sets bit 4 only when `check_en[2]` is 1. `ev_map_crc` sets bit 3 only when `check_en[3]` is 1.
- R10: The check-enable register sits at address 0Ah. Its bits [3:0] are address, bit-count, link CRC and map CRC, and a write loads them from `wdata[3:0]` only when `map_wr_go` is high.
- R11: Bit 7 of `status` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Decoded register write strobe |
| rd_en | input | 1 | Decoded register read strobe |
| addr | input | 8 | Register address of the access |
| wdata | input | 8 | Write data |
| ev_supply_low | input | 1 | Supply dropout event pulse |
| ev_reset_seen | input | 1 | Reset or software-reset event pulse |
| ev_link_crc | input | 1 | Link CRC failure pulse |
| ev_map_crc | input | 1 | Register-map CRC failure pulse |
| ev_core_err | input | 1 | Internal converter fault pulse |
| frame_end | input | 1 | End-of-frame pulse |
| frame_bits | input | 8 | Serial clock count of the ending frame |
| status | output | 8 | Sticky status byte |
| check_en | output | 4 | Check enables: addr, bit-count, link CRC, map CRC |
| map_wr_go | output | 1 | Write permit for the rest of the map |

## Verification
The bench builds the block with its default parameters: an 8-bit address, an upper valid address of 50h, an 8-bit frame count, and an eight-clock word. With these values every address and every write-data byte can be swept exhaustively. Each of the 256 clear patterns is applied to a fully set status byte. Every address is checked once against the write permit and once against the address check. The frame counts 0 to 31 cover four complete word multiples and all the remainders between them.

// File: rtl/stat_guard_pkg.sv
// Shared constants for the sticky status block: flag positions, reset
// values, the clear and lock masks, and the check-enable bit order.
package stat_guard_pkg;
    localparam int NFLAG    = 7;
    localparam int NCHK     = 4;

    localparam int F_BITCNT = 0;
    localparam int F_ADDR   = 1;
    localparam int F_CORE   = 2;
    localparam int F_MAPCRC = 3;
    localparam int F_LINK   = 4;
    localparam int F_RSTSEEN = 5;
    localparam int F_SUPPLY = 6;

    localparam logic [NFLAG-1:0] FLAG_RST  = 7'h60;
    localparam logic [NFLAG-1:0] CLR_MASK  = 7'h7B;
    localparam logic [NFLAG-1:0] LOCK_MASK = 7'h13;

    localparam int C_ADDR   = 0;
    localparam int C_BITCNT = 1;
    localparam int C_LINK   = 2;
    localparam int C_MAP    = 3;

    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/stat_guard_access.sv
// Access decoder. It classifies each register access and each frame end.
// Outputs: the status-write hit, the write permit for the rest of the map,
// the load strobe of the check-enable register, and the address and
// bit-count error events.
// Assumes: at most one access strobe per cycle, and that frame_bits holds
// the clock count of the frame that ends with the frame_end pulse.
module stat_guard_access #(
    parameter int          ADDR_W     = 8,
    parameter int          CNT_W      = 8,
    parameter int          WORD_BITS  = 8,
    parameter logic [7:0]  MAX_ADDR   = 8'h50,
    parameter logic [7:0]  STAT_ADDR  = 8'h02,
    parameter logic [7:0]  CHKEN_ADDR = 8'h0A
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  frame_bits,
    input  logic              chk_addr_on,
    input  logic              chk_bits_on,
    input  logic              locked,
    output logic              stat_wr_hit,
    output logic              map_wr_go,
    output logic              chken_load,
    output logic              addr_bad_ev,
    output logic              bitcnt_ev
);
    localparam int WORD_LSB = $clog2(WORD_BITS);
    localparam logic [ADDR_W-1:0] MAX_A   = ADDR_W'(MAX_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] CHKEN_A = ADDR_W'(CHKEN_ADDR);

    logic in_range;
    logic unused_frame_hi;

    // Decide whether the presented address falls inside the register map.
    always_comb in_range = (addr <= MAX_A);

    // Classify the write and produce the permit for the rest of the map.
    always_comb begin
        stat_wr_hit = wr_en && (addr == STAT_A);
        map_wr_go   = wr_en && in_range && (addr != STAT_A) && !locked;
        chken_load  = map_wr_go && (addr == CHKEN_A);
    end

    // Raise the error events of the two checks that are made here.
    always_comb begin
        addr_bad_ev = (wr_en || rd_en) && !in_range && chk_addr_on;
        bitcnt_ev   = frame_end && chk_bits_on && (frame_bits[WORD_LSB-1:0] != '0);
    end

    assign unused_frame_hi = ^frame_bits[CNT_W-1:WORD_LSB];
endmodule

// File: rtl/stat_guard_flags.sv
// Sticky flag bank. Each flag is set by its event and cleared either by a
// write of one (clearable flags) or only by reset (sticky-only flags).
// A set always beats a clear in the same cycle.
// Assumes: clr_vec is already qualified by a write to the status address.
module stat_guard_flags
    import stat_guard_pkg::*;
#(
    parameter int              NF      = NFLAG,
    parameter logic [NF-1:0]   RST_VAL = FLAG_RST,
    parameter logic [NF-1:0]   CLR_OK  = CLR_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        if (CLR_OK[i]) begin : g_w1c
            // Clearable flag: a set beats a clear, and a clear needs a one written.
            always_ff @(posedge clk) begin
                if (!rst_n)          flags[i] <= RST_VAL[i];
                else if (set_vec[i]) flags[i] <= 1'b1;
                else if (clr_vec[i]) flags[i] <= 1'b0;
            end
        end else begin : g_sticky
            logic unused_clr;
            assign unused_clr = clr_vec[i];
            // Reset-only flag: once set, only a reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)          flags[i] <= RST_VAL[i];
                else if (set_vec[i]) flags[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stat_guard_chken.sv
// Check-enable register. It holds one enable bit per check and loads from
// the write data on a permitted write to its address.
// Assumes: the load strobe already includes the write lockout.
module stat_guard_chken #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NC-1:0] din,
    output logic [NC-1:0] en
);
    // Hold the enables: cleared on reset, loaded on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)    en <= '0;
        else if (load) en <= din;
    end
endmodule

// File: rtl/stat_guard.sv
// Sticky status byte with write lockout. It gathers event pulses into
// sticky flags, clears them on write-one, and withholds the write permit
// for the rest of the map while a link-integrity flag is pending.
// Assumes: decoded single-cycle strobes and single-cycle event pulses.
module stat_guard
    import stat_guard_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          CNT_W      = 8,
    parameter int          WORD_BITS  = 8,
    parameter logic [7:0]  MAX_ADDR   = 8'h50,
    parameter logic [7:0]  STAT_ADDR  = 8'h02,
    parameter logic [7:0]  CHKEN_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ev_supply_low,
    input  logic              ev_reset_seen,
    input  logic              ev_link_crc,
    input  logic              ev_map_crc,
    input  logic              ev_core_err,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  frame_bits,
    output logic [7:0]        status,
    output logic [NCHK-1:0]   check_en,
    output logic              map_wr_go
);
    flag_vec_t flags, set_vec, clr_vec;
    logic      stat_wr_hit, chken_load, addr_bad_ev, bitcnt_ev, locked;
    logic      unused_wdata_top;

    // Any pending link-integrity flag freezes writes to the rest of the map.
    always_comb locked = |(flags & LOCK_MASK);

    stat_guard_access #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BITS(WORD_BITS),
        .MAX_ADDR(MAX_ADDR), .STAT_ADDR(STAT_ADDR), .CHKEN_ADDR(CHKEN_ADDR)
    ) u_access (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .frame_end(frame_end), .frame_bits(frame_bits),
        .chk_addr_on(check_en[C_ADDR]), .chk_bits_on(check_en[C_BITCNT]),
        .locked(locked), .stat_wr_hit(stat_wr_hit), .map_wr_go(map_wr_go),
        .chken_load(chken_load), .addr_bad_ev(addr_bad_ev), .bitcnt_ev(bitcnt_ev)
    );

    // Gather the set events, each gated by its check enable where it has one.
    always_comb begin
        set_vec            = '0;
        set_vec[F_SUPPLY]  = ev_supply_low;
        set_vec[F_RSTSEEN] = ev_reset_seen;
        set_vec[F_LINK]    = ev_link_crc && check_en[C_LINK];
        set_vec[F_MAPCRC]  = ev_map_crc && check_en[C_MAP];
        set_vec[F_CORE]    = ev_core_err;
        set_vec[F_ADDR]    = addr_bad_ev;
        set_vec[F_BITCNT]  = bitcnt_ev;
    end

    // Clear requests come only from a write to the status address.
    always_comb clr_vec = stat_wr_hit ? wdata[NFLAG-1:0] : '0;

    stat_guard_flags #(
        .NF(NFLAG), .RST_VAL(FLAG_RST), .CLR_OK(CLR_MASK)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
    );

    stat_guard_chken #(.NC(NCHK)) u_chken (
        .clk(clk), .rst_n(rst_n), .load(chken_load),
        .din(wdata[NCHK-1:0]), .en(check_en)
    );

    // Present the byte with its top bit reserved as zero.
    always_comb status = {1'b0, flags};

    assign unused_wdata_top = wdata[7];
endmodule

// File: rtl/stat_guard_chk.sv
// Property checker for stat_guard, attached to it by the bind below.
module stat_guard_chk
    import stat_guard_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         CNT_W    = 8,
    parameter logic [7:0] MAX_ADDR = 8'h50,
    parameter logic [7:0] STAT_ADDR = 8'h02
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              ev_supply_low,
    input logic              frame_end,
    input logic [CNT_W-1:0]  frame_bits,
    input logic [7:0]        status,
    input logic [NCHK-1:0]   check_en,
    input logic              map_wr_go
);
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 8'h60 && check_en == '0));

    assert_w1c_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(STAT_ADDR) && wdata[F_SUPPLY] && !ev_supply_low)
        |=> !status[F_SUPPLY]);

    assert_core_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[F_CORE] |=> status[F_CORE]);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_supply_low |=> status[F_SUPPLY]);

    assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_go |-> (status[F_LINK] == 1'b0 && status[F_ADDR] == 1'b0 && status[F_BITCNT] == 1'b0));

    assert_addr_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && check_en[C_ADDR] && addr > ADDR_W'(MAX_ADDR)) |=> status[F_ADDR]);

    assert_bitcnt_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && check_en[C_BITCNT] && frame_bits[2:0] != 3'd0) |=> status[F_BITCNT]);

    assert_en_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[F_LINK] || status[F_ADDR] || status[F_BITCNT]) |=> $stable(check_en));
endmodule

bind stat_guard stat_guard_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_ADDR(MAX_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ev_supply_low(ev_supply_low), .frame_end(frame_end),
    .frame_bits(frame_bits), .status(status), .check_en(check_en),
    .map_wr_go(map_wr_go)
);

// File: tb/stat_guard_tb_top.sv
// Self-checking bench for stat_guard: sweeps of write data, addresses and
// frame counts, with expected values computed from the requirements.
module stat_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       ev_supply_low = 1'b0, ev_reset_seen = 1'b0, ev_link_crc = 1'b0;
    logic       ev_map_crc = 1'b0, ev_core_err = 1'b0, frame_end = 1'b0;
    logic [7:0] frame_bits = '0;
    logic [7:0] status;
    logic [3:0] check_en;
    logic       map_wr_go;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stat_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ev_supply_low(ev_supply_low), .ev_reset_seen(ev_reset_seen),
        .ev_link_crc(ev_link_crc), .ev_map_crc(ev_map_crc), .ev_core_err(ev_core_err),
        .frame_end(frame_end), .frame_bits(frame_bits), .status(status),
        .check_en(check_en), .map_wr_go(map_wr_go)
    );

    task automatic idle();
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        ev_supply_low = 0; ev_reset_seen = 0; ev_link_crc = 0;
        ev_map_crc = 0; ev_core_err = 0; frame_end = 0; frame_bits = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", status, 8'h60);
        check("R1", {4'h0, check_en}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R1", status, 8'h60);

        // R10: enables load when unlocked
        wr(8'h0A, 8'hFF);
        check("R10", {4'h0, check_en}, 8'h0F);
        // R3: clear the reset-time flags
        wr(8'h02, 8'h7F);
        check("R3", status, 8'h00);

        // R2: every event reaches its own bit
        ev_supply_low = 1; tick(); check("R2", status, 8'h40); wr(8'h02, 8'hFF);
        ev_reset_seen = 1; tick(); check("R2", status, 8'h20); wr(8'h02, 8'hFF);
        ev_link_crc = 1;   tick(); check("R2", status, 8'h10); wr(8'h02, 8'hFF);
        ev_map_crc = 1;    tick(); check("R2", status, 8'h08); wr(8'h02, 8'hFF);
        rd_en = 1; addr = 8'h51; tick(); check("R2", status, 8'h02); wr(8'h02, 8'hFF);
        frame_end = 1; frame_bits = 8'd3; tick(); check("R2", status, 8'h01); wr(8'h02, 8'hFF);
        check("R2", status, 8'h00);
        ev_core_err = 1;   tick(); check("R2", status, 8'h04);
        // R4: converter fault ignores a clearing write
        wr(8'h02, 8'hFF);
        check("R4", status, 8'h04);

        // R3/R11: every write pattern against a fully set byte
        for (int w = 0; w < 256; w++) begin
            ev_supply_low = 1; ev_reset_seen = 1; ev_link_crc = 1; ev_map_crc = 1;
            frame_end = 1; frame_bits = 8'd1;
            tick();
            rd_en = 1; addr = 8'hFF; tick();
            check("R3", status, 8'h7F);
            wr(8'h02, 8'(w));
            check("R3", status, 8'h7F & ~(8'(w) & 8'h7B));
        end
        wr(8'h02, 8'hFF);
        check("R11", status, 8'h04);

        // R5: set and clear on the same bit in one cycle
        ev_link_crc = 1; wr_en = 1; addr = 8'h02; wdata = 8'h10;
        tick();
        check("R5", status, 8'h14);

        // R6/R10: locked by link CRC flag, nothing else may be written
        for (int a = 0; a < 256; a++) begin
            wr_en = 1; addr = 8'(a); wdata = 8'h00;
            #1;
            check("R6", {7'h0, map_wr_go}, 8'h00);
            tick();
        end
        wr(8'h0A, 8'h00);
        check("R10", {4'h0, check_en}, 8'h0F);
        wr(8'h02, 8'hFF);
        check("R6", status, 8'h04);

        // R6: locked by the address flag
        rd_en = 1; addr = 8'h60; tick();
        check("R6", status, 8'h06);
        wr_en = 1; addr = 8'h10; #1;
        check("R6", {7'h0, map_wr_go}, 8'h00);
        tick();
        wr(8'h02, 8'h02);
        wr_en = 1; addr = 8'h10; #1;
        check("R6", {7'h0, map_wr_go}, 8'h01);
        tick();

        // R6: unlocked permit over every address, checks off
        wr(8'h0A, 8'h00);
        check("R10", {4'h0, check_en}, 8'h00);
        for (int a = 0; a < 256; a++) begin
            wr_en = 1; addr = 8'(a); wdata = 8'h00;
            #1;
            check("R6", {7'h0, map_wr_go}, (a <= 'h50 && a != 2) ? 8'h01 : 8'h00);
            tick();
        end
        check("R6", status, 8'h04);

        // R7: address check off has no effect
        rd_en = 1; addr = 8'hFF; tick();
        check("R7", status, 8'h04);
        // R7: address sweep with the check on
        wr(8'h0A, 8'h01);
        for (int a = 0; a < 256; a++) begin
            rd_en = 1; addr = 8'(a); tick();
            check("R7", status, (a > 'h50) ? 8'h06 : 8'h04);
            if (a > 'h50) wr(8'h02, 8'h02);
        end

        // R8: frame count sweep with the check on
        wr(8'h0A, 8'h02);
        for (int n = 0; n < 32; n++) begin
            frame_end = 1; frame_bits = 8'(n); tick();
            check("R8", status, (n % 8 != 0) ? 8'h05 : 8'h04);
            wr(8'h02, 8'h01);
        end
        wr(8'h0A, 8'h00);
        frame_end = 1; frame_bits = 8'd5; tick();
        check("R8", status, 8'h04);

        // R9: CRC events honour their enables
        ev_link_crc = 1; ev_map_crc = 1; tick();
        check("R9", status, 8'h04);
        wr(8'h0A, 8'h04);
        ev_link_crc = 1; ev_map_crc = 1; tick();
        check("R9", status, 8'h14);
        wr(8'h02, 8'hFF);
        wr(8'h0A, 8'h08);
        ev_link_crc = 1; ev_map_crc = 1; tick();
        check("R9", status, 8'h0C);

        // R4/R1: a reset clears the converter fault
        rst_n = 0; tick(); rst_n = 1; @(negedge clk);
        check("R4", status, 8'h60);
        check("R1", {4'h0, check_en}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule